// File: doc/BRIEF.md
# Relative Branch Outcome Unit

This unit settles a short conditional branch of an 8-bit controller. It receives the branch opcode byte, the signed displacement byte that follows it, the address at which the branch instruction sits, and the four arithmetic status flags (negative, zero, overflow, carry). One clock edge later it reports whether the branch is taken and which address execution continues from. It also raises a flag when the opcode is not a branch it knows.

The unit decodes sixteen opcodes, 0x20 to 0x2F. They cover four groups: the unconditional pair (always and never), the unsigned magnitude tests built from carry and zero, the single-flag tests, and the signed magnitude tests built from zero and the exclusive-or of negative and overflow. Every branch is two bytes long. The continuation address is therefore the instruction address plus two when the branch is not taken. When it is taken, the sign-extended displacement is added on top. All address arithmetic wraps modulo 2^16. A request is marked by a valid strobe, and the outputs hold their last values between requests.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid`, `taken` and `bad_op` are 0 and `next_pc` is 0x0000.
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high and `rst` was low.
- R3: A result that is not taken gives `next_pc` = `insn_addr` + 2, modulo 2^16.
- R4: A taken result gives `next_pc` = `insn_addr` + 2 + offset, modulo 2^16, where `offset` is a two's-complement byte sign-extended to 16 bits.
- R5: Opcode 0x20 is always taken and opcode 0x21 is never taken, whatever the flags.
- R6: Unsigned tests: 0x22 is taken when (C | Z) = 0, 0x23 when (C | Z) = 1, 0x24 when C = 0 and 0x25 when C = 1.
- R7: Single-flag tests: 0x26 is taken when Z = 0, 0x27 when Z = 1, 0x28 when V = 0, 0x29 when V = 1, 0x2A when N = 0 and 0x2B when N = 1.
- R8: Signed tests: 0x2C is taken when (N ^ V) = 0, 0x2D when (N ^ V) = 1, 0x2E when (Z | (N ^ V)) = 0 and 0x2F when (Z | (N ^ V)) = 1.
- R9: An opcode outside 0x20..0x2F gives `taken` = 0 and `bad_op` = 1, with `next_pc` = `insn_addr` + 2. A valid opcode gives `bad_op` = 0.
- R10: A cycle with `in_valid` low leaves `taken`, `next_pc` and `bad_op` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Branch opcode byte |
| offset | input | 8 | Signed displacement byte |
| insn_addr | input | 16 | Address of the branch opcode |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Result present this cycle |
| taken | output | 1 | Branch is taken |
| next_pc | output | 16 | Continuation address |
| bad_op | output | 1 | Opcode is not a known branch |

## Verification
The bench applies all 256 opcode values under all 16 flag combinations. This catches a condition swapped between a test and its complement, or a signed test that uses OR where it should use XOR: the taken output would be inverted for part of the flag space. Displacements 0x80 and 0x7F at addresses near 0x0000 and 0xFFFF expose a zero-extended offset or a missing +2, because the target lands 256 or 2 bytes away from the true one. Idle cycles with changing inputs expose outputs that follow the inputs without waiting for the strobe.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam logic [7:0] BR_OP_BASE = 8'h20;
  localparam int         BR_LEN     = 2;

  // Order of members follows the low nibble of the opcode.
  typedef enum logic [3:0] {
    C_ALWAYS  = 4'h0,
    C_NEVER   = 4'h1,
    C_UGT     = 4'h2,
    C_ULE     = 4'h3,
    C_CARRY0  = 4'h4,
    C_CARRY1  = 4'h5,
    C_ZERO0   = 4'h6,
    C_ZERO1   = 4'h7,
    C_OVF0    = 4'h8,
    C_OVF1    = 4'h9,
    C_NEG0    = 4'hA,
    C_NEG1    = 4'hB,
    C_SGE     = 4'hC,
    C_SLT     = 4'hD,
    C_SGT     = 4'hE,
    C_SLE     = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/brres_decode.sv
module brres_decode
  import brres_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output cond_e           cond,
  output logic            known
);
  localparam int HI_W = OP_W - 4;
  localparam logic [OP_W-1:0] BASE = OP_W'(BR_OP_BASE);

  always_comb begin
    known = (opcode[OP_W-1:4] == BASE[OP_W-1:4]);
    cond  = cond_e'(opcode[3:0]);
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = BASE[OP_W-1:4];
endmodule

// File: rtl/brres_cond_eval.sv
module brres_cond_eval
  import brres_pkg::*;
(
  input  cond_e  cond,
  input  logic   known,
  input  flags_t fl,
  output logic   take
);
  logic sgn_lt;
  logic u_le;
  logic s_le;
  logic raw;

  always_comb begin
    sgn_lt = fl.n ^ fl.v;
    u_le   = fl.c | fl.z;
    s_le   = fl.z | sgn_lt;
    unique case (cond)
      C_ALWAYS: raw = 1'b1;
      C_NEVER:  raw = 1'b0;
      C_UGT:    raw = ~u_le;
      C_ULE:    raw = u_le;
      C_CARRY0: raw = ~fl.c;
      C_CARRY1: raw = fl.c;
      C_ZERO0:  raw = ~fl.z;
      C_ZERO1:  raw = fl.z;
      C_OVF0:   raw = ~fl.v;
      C_OVF1:   raw = fl.v;
      C_NEG0:   raw = ~fl.n;
      C_NEG1:   raw = fl.n;
      C_SGE:    raw = ~sgn_lt;
      C_SLT:    raw = sgn_lt;
      C_SGT:    raw = ~s_le;
      C_SLE:    raw = s_le;
      default:  raw = 1'b0;
    endcase
    take = known & raw;
  end
endmodule

// File: rtl/brres_target.sv
module brres_target #(
  parameter int ADDR_W   = 16,
  parameter int OFFS_W   = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [OFFS_W-1:0] offset,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] jump_pc
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset[OFFS_W-1]}}, offset};
    seq_pc  = insn_addr + ADDR_W'(INSN_LEN);
    jump_pc = seq_pc + off_ext;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [OFFS_W-1:0] offset,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              bad_op
);
  cond_e             cond;
  logic              known;
  logic              take_c;
  flags_t            fl;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] jump_pc;

  assign fl = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brres_decode #(.OP_W(OP_W)) u_dec (
    .opcode (opcode),
    .cond   (cond),
    .known  (known)
  );

  brres_cond_eval u_eval (
    .cond  (cond),
    .known (known),
    .fl    (fl),
    .take  (take_c)
  );

  brres_target #(
    .ADDR_W   (ADDR_W),
    .OFFS_W   (OFFS_W),
    .INSN_LEN (BR_LEN)
  ) u_tgt (
    .insn_addr (insn_addr),
    .offset    (offset),
    .seq_pc    (seq_pc),
    .jump_pc   (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= take_c;
        next_pc <= take_c ? jump_pc : seq_pc;
        bad_op  <= ~known;
      end
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8,
  parameter int OP_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   opcode,
  input logic [OFFS_W-1:0] offset,
  input logic [ADDR_W-1:0] insn_addr,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              bad_op
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && !bad_op && next_pc == '0));

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !$past(rst)) |=> (taken || next_pc == $past(insn_addr) + ADDR_W'(2)));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !$past(rst)) |=> (!taken || next_pc == $past(insn_addr) + ADDR_W'(2)
        + {{EXT_W{$past(offset[OFFS_W-1])}}, $past(offset)}));

  // R5
  never_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_W'(8'h21)) |=> !taken);

  // R9
  bad_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> !taken);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(taken) && $stable(next_pc) && $stable(bad_op)));
endmodule

bind branch_resolver branch_resolver_chk #(
  .ADDR_W (ADDR_W),
  .OFFS_W (OFFS_W),
  .OP_W   (OP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .offset    (offset),
  .insn_addr (insn_addr),
  .out_valid (out_valid),
  .taken     (taken),
  .next_pc   (next_pc),
  .bad_op    (bad_op)
);

// File: tb/branch_resolver_tb.sv
`timescale 1ns/1ps
module branch_resolver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  offset = '0;
  logic [15:0] insn_addr = '0;
  logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic        out_valid, taken, bad_op;
  logic [15:0] next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  branch_resolver u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .offset(offset), .insn_addr(insn_addr), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc), .bad_op(bad_op)
  );

  function automatic logic exp_take(input logic [7:0] op, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (op)
      8'h20: return 1'b1;
      8'h21: return 1'b0;
      8'h22: return (c | z) == 1'b0;
      8'h23: return (c | z) == 1'b1;
      8'h24: return c == 1'b0;
      8'h25: return c == 1'b1;
      8'h26: return z == 1'b0;
      8'h27: return z == 1'b1;
      8'h28: return v == 1'b0;
      8'h29: return v == 1'b1;
      8'h2A: return n == 1'b0;
      8'h2B: return n == 1'b1;
      8'h2C: return (n ^ v) == 1'b0;
      8'h2D: return (n ^ v) == 1'b1;
      8'h2E: return (z | (n ^ v)) == 1'b0;
      8'h2F: return (z | (n ^ v)) == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string group_tag(input logic [7:0] op);
    if (op == 8'h20 || op == 8'h21) return "R5";
    if (op >= 8'h22 && op <= 8'h25) return "R6";
    if (op >= 8'h26 && op <= 8'h2B) return "R7";
    if (op >= 8'h2C && op <= 8'h2F) return "R8";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, result sampled at the following negedge.
  task automatic apply(input logic [7:0] op, input logic [7:0] off,
                       input logic [15:0] addr, input logic [3:0] f);
    logic        et;
    logic [15:0] ep;
    opcode = op; offset = off; insn_addr = addr;
    {flag_n, flag_z, flag_v, flag_c} = f;
    in_valid = 1'b1;
    @(negedge clk);
    et = exp_take(op, f);
    ep = addr + 16'd2 + (et ? {{8{off[7]}}, off} : 16'd0);
    check(out_valid == 1'b1, "R2", "out_valid", out_valid, 1);
    check(taken == et, group_tag(op), "taken", taken, et);
    check(bad_op == (op[7:4] != 4'h2), "R9", "bad_op", bad_op, op[7:4] != 4'h2);
    check(next_pc == ep, et ? "R4" : "R3", "next_pc", next_pc, ep);
  endtask

  initial begin
    logic [15:0] hold_pc;
    logic        hold_tk;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && taken == 0 && bad_op == 0 && next_pc == 0,
          "R1", "reset outputs", {out_valid, taken, bad_op, next_pc}, 0);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 0 && next_pc == 0, "R1", "after reset",
          {out_valid, next_pc}, 0);

    // Exhaustive opcode x flags sweep
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 16; f++) begin
        apply(8'(op), 8'(op * 7 + f * 37), 16'(op * 251 + f * 4099), 4'(f));
      end
    end

    // R4 wrap corners
    apply(8'h20, 8'h7F, 16'hFFFE, 4'h0);
    check(next_pc == 16'h007F, "R4", "wrap forward", next_pc, 16'h007F);
    apply(8'h20, 8'h80, 16'h0000, 4'h0);
    check(next_pc == 16'hFF82, "R4", "wrap backward", next_pc, 16'hFF82);
    apply(8'h20, 8'hFE, 16'h1234, 4'hF);
    check(next_pc == 16'h1234, "R4", "self loop", next_pc, 16'h1234);
    // R3 wrap corner
    apply(8'h21, 8'h55, 16'hFFFF, 4'h0);
    check(next_pc == 16'h0001, "R3", "fallthrough wrap", next_pc, 16'h0001);

    // R10: idle cycles with moving inputs
    apply(8'h27, 8'h10, 16'h4000, 4'b0100);
    hold_pc = next_pc; hold_tk = taken;
    in_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      opcode = 8'(8'h20 + i); offset = 8'(i * 31); insn_addr = 16'(i * 999);
      {flag_n, flag_z, flag_v, flag_c} = 4'(i);
      @(negedge clk);
      check(out_valid == 0, "R2", "idle out_valid", out_valid, 0);
      check(next_pc == hold_pc && taken == hold_tk && bad_op == 0, "R10",
            "hold", {taken, next_pc}, {hold_tk, hold_pc});
    end

    // R1: reset in the middle of traffic
    apply(8'h20, 8'h22, 16'h8000, 4'h0);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && taken == 0 && next_pc == 0, "R1", "mid reset",
          {out_valid, taken, next_pc}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule